// File: doc/BRIEF.md
# Register slave with flopped read data on the peripheral bus

This block is a small register slave on the APB peripheral bus. It holds a software control word, a write-1-to-clear interrupt flag word that hardware sets, and a command location that only accepts writes. It also presents a read-only status input and the head entry of an external FIFO. Software reads any of these as full 32-bit words.

Read data is not driven straight from the address selector. In the first access cycle of a read, the selected word is captured into a flop and PREADY is held low. One cycle later, PREADY rises and the captured word appears on PRDATA. This keeps the decode-and-select path inside one clock period. Because PREADY comes from the same stage, the master samples PRDATA in the cycle in which the data becomes valid.

A read of the FIFO offset produces a single-cycle pop strobe, and only in the cycle the read completes. Outside its own selection the slave drives PRDATA to zero, so several slaves can feed one OR-combined read bus.

Top module: `apb_rs_slave`

## Requirements
- R1: While PRESETN is low, and directly after it rises, PRDATA reads zero, PREADY is low, the pop strobe and command pulse are low, and the control and flag words are zero.
- R2: Every read takes two access-phase cycles. PREADY is low in the first access cycle and high in the second, and the captured word is on PRDATA in that second cycle.
- R3: Reads return the full 32-bit word of the addressed location. Offset 0x000 returns the control word, 0x004 the live status input, 0x008 the interrupt flags, and 0x00C the FIFO head entry.
- R4: A read of any offset that is not mapped returns 32'h0 and never an unknown value. This includes offsets that are not word-aligned and offsets beyond 0x010.
- R5: A write to 0x010 stores its data on the command-word output and raises the command pulse for exactly one cycle, starting the cycle after the write completes. A read of 0x010 returns zero.
- R6: Whenever PSEL is low, PRDATA is 32'h0.
- R7: The FIFO pop strobe is high for exactly one cycle per completed read of 0x00C, and only in that completion cycle. It never fires in the wait cycle, on a write, or on a read of any other offset.
- R8: Writes complete with zero wait states: PREADY is high in the first access cycle. A write to 0x000 replaces the control word.
- R9: A write to 0x004 has no effect; later reads still return the live status input.
- R10: A one-cycle pulse on irq_set sets the matching flag bits. A write to 0x008 clears the flag bits written as 1. When a set and a clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when unselected |
| pready | output | 1 | Transfer completes when high in access phase |
| status_in | input | 32 | Read-only status word from hardware |
| irq_set | input | 32 | Per-bit flag set pulses |
| fifo_head | input | 32 | Head entry of the external FIFO |
| fifo_pop | output | 1 | One-cycle pop strobe on FIFO read completion |
| ctrl_out | output | 32 | Control word |
| cmd_word | output | 32 | Last word written to the command location |
| cmd_pulse | output | 1 | One-cycle pulse after a command write |

## Verification
The flag word has two writers that can act in the same cycle: a hardware set pulse and a software write-1 clear. The bench provokes this by driving irq_set on a bit during the access cycle of a write that clears that same bit. It then reads the flags back through the bus, and expects the bit to still be set. The bench also checks that a pop falls only in the completion cycle of a waited read and never in that read's wait cycle. It counts pops against the number of FIFO reads issued.

// File: rtl/apb_rs_pkg.sv
package apb_rs_pkg;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_STAT = 'h004;
    localparam int OFS_FLAG = 'h008;
    localparam int OFS_FIFO = 'h00C;
    localparam int OFS_CMD  = 'h010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_FLAG,
        SEL_FIFO,
        SEL_CMD
    } sel_e;

endpackage

// File: rtl/apb_rs_decode.sv
module apb_rs_decode
    import apb_rs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    always_comb begin
        case (addr)
            ADDR_W'(OFS_CTRL): sel = SEL_CTRL;
            ADDR_W'(OFS_STAT): sel = SEL_STAT;
            ADDR_W'(OFS_FLAG): sel = SEL_FLAG;
            ADDR_W'(OFS_FIFO): sel = SEL_FIFO;
            ADDR_W'(OFS_CMD):  sel = SEL_CMD;
            default:           sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/apb_rs_regs.sv
module apb_rs_regs
    import apb_rs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] irq_set,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] cmd_word,
    output logic              cmd_pulse
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] flags;
        logic [DATA_W-1:0] cmd;
        logic              pulse;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.flags = st_q.flags | irq_set;
        if (wr_done) begin
            case (sel)
                SEL_CTRL: st_d.ctrl = wdata;
                SEL_FLAG: st_d.flags = (st_q.flags & ~wdata) | irq_set;
                SEL_CMD: begin
                    st_d.cmd   = wdata;
                    st_d.pulse = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl      = st_q.ctrl;
    assign flags     = st_q.flags;
    assign cmd_word  = st_q.cmd;
    assign cmd_pulse = st_q.pulse;

    AST_CMD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |=> !cmd_pulse); // R5
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != '0) |=> ((flags & $past(irq_set)) == $past(irq_set))); // R10

endmodule

// File: rtl/apb_rs_rdpipe.sv
module apb_rs_rdpipe
    import apb_rs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] fifo_head,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              fifo_pop
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rdy;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic [DATA_W-1:0] mux_val;
    logic              rd_acc;
    logic              rd_done;

    assign rd_acc = psel & penable & ~pwrite;

    always_comb begin
        case (sel)
            SEL_CTRL: mux_val = ctrl;
            SEL_STAT: mux_val = status;
            SEL_FLAG: mux_val = flags;
            SEL_FIFO: mux_val = fifo_head;
            default:  mux_val = '0;
        endcase
    end

    always_comb begin
        st_d.rdy   = rd_acc & ~st_q.rdy;
        st_d.rdata = (rd_acc & ~st_q.rdy) ? mux_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pready   = st_q.rdy | (psel & pwrite);
    assign prdata   = psel ? st_q.rdata : '0;
    assign rd_done  = rd_acc & pready;
    assign fifo_pop = rd_done & (sel == SEL_FIFO);

    AST_READ_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(penable) && psel && !pwrite) |-> !pready); // R2
    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !pready) |=> pready); // R2
    AST_POP_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(rd_acc && !pready)); // R7
    AST_DONE_NO_X: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !$isunknown(prdata)); // R4

endmodule

// File: rtl/apb_rs_slave.sv
module apb_rs_slave
    import apb_rs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] irq_set,
    input  logic [DATA_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0] cmd_word,
    output logic              cmd_pulse
);

    sel_e              sel;
    logic [DATA_W-1:0] flags;
    logic              wr_done;

    assign wr_done = psel & penable & pwrite & pready;

    apb_rs_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .sel  (sel)
    );

    apb_rs_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_done   (wr_done),
        .sel       (sel),
        .wdata     (pwdata),
        .irq_set   (irq_set),
        .ctrl      (ctrl_out),
        .flags     (flags),
        .cmd_word  (cmd_word),
        .cmd_pulse (cmd_pulse)
    );

    apb_rs_rdpipe #(.DATA_W(DATA_W)) u_rd (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .sel       (sel),
        .ctrl      (ctrl_out),
        .status    (status_in),
        .flags     (flags),
        .fifo_head (fifo_head),
        .prdata    (prdata),
        .pready    (pready),
        .fifo_pop  (fifo_pop)
    );

    AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && pready && (sel == SEL_NONE || sel == SEL_CMD))
        |-> (prdata == '0)); // R4 R5
    AST_WRITE_NO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite) |-> (pready && !fifo_pop)); // R8

endmodule

// File: tb/apb_rs_slave_bench.sv
`timescale 1ns/1ps
module apb_rs_slave_bench;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [31:0] status_in = '0, irq_set = '0, fifo_head = '0;
    logic        fifo_pop;
    logic [31:0] ctrl_out, cmd_word;
    logic        cmd_pulse;

    int checks = 0;
    int fails  = 0;
    int pops_seen = 0;
    int pops_exp  = 0;

    typedef struct {
        logic [31:0] data;
        logic        pop;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #2.5 pclk = ~pclk;

    apb_rs_slave u_apb_rs_slave (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .status_in(status_in), .irq_set(irq_set),
        .fifo_head(fifo_head), .fifo_pop(fifo_pop), .ctrl_out(ctrl_out),
        .cmd_word(cmd_word), .cmd_pulse(cmd_pulse)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares every completed read against the scoreboard queue
    always @(negedge pclk) begin
        if (presetn) begin
            if (fifo_pop) pops_seen++;
            if (!psel) chk(prdata == 32'h0, "R6 idle prdata", prdata, 32'h0);
            if (fifo_pop && !(psel && penable && !pwrite && pready))
                chk(1'b0, "R7 pop outside read completion", 32'(fifo_pop), 32'h0);
            if (psel && penable && !pwrite && pready) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2 unexpected completion", prdata, 32'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(prdata == e.data, e.req, prdata, e.data);
                    chk(fifo_pop == e.pop, "R7 pop at completion",
                        32'(fifo_pop), 32'(e.pop));
                end
            end
        end
    end

    task automatic apb_read(input logic [11:0] a, input logic [31:0] exp,
                            input logic pop, input string req);
        exp_t e;
        e.data = exp; e.pop = pop; e.req = req;
        sbq.push_back(e);
        if (pop) pops_exp++;
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(negedge pclk);
        chk(pready == 1'b0, "R2 first access cycle waits", 32'(pready), 32'h0);
        chk(fifo_pop == 1'b0, "R7 no pop in wait cycle", 32'(fifo_pop), 32'h0);
        @(posedge pclk);
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [31:0] irq);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1; irq_set = irq;
        @(negedge pclk);
        chk(pready == 1'b1, "R8 write has no wait", 32'(pready), 32'h1);
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; irq_set = '0;
    endtask

    task automatic irq_pulse(input logic [31:0] v);
        @(posedge pclk); #1; irq_set = v;
        @(posedge pclk); #1; irq_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        // R1: state during reset
        chk(prdata == 0, "R1 prdata in reset", prdata, 0);
        chk(pready == 0, "R1 pready in reset", 32'(pready), 0);
        chk(fifo_pop == 0, "R1 pop in reset", 32'(fifo_pop), 0);
        chk(ctrl_out == 0, "R1 ctrl in reset", ctrl_out, 0);
        chk(cmd_pulse == 0, "R1 cmd pulse in reset", 32'(cmd_pulse), 0);
        @(posedge pclk); #1; presetn = 1'b1;
        status_in = 32'hA5A5_1234;
        fifo_head = 32'hDEAD_BEEF;

        apb_read(12'h000, 32'h0, 1'b0, "R1 control reads zero after reset");
        apb_read(12'h008, 32'h0, 1'b0, "R1 flags read zero after reset");

        // R8 / R3 control word
        apb_write(12'h000, 32'h1357_9BDF, '0);
        @(negedge pclk);
        chk(ctrl_out == 32'h1357_9BDF, "R8 ctrl_out updated", ctrl_out, 32'h1357_9BDF);
        apb_read(12'h000, 32'h1357_9BDF, 1'b0, "R3 control readback");

        // R3 / R9 status
        apb_read(12'h004, 32'hA5A5_1234, 1'b0, "R3 status read");
        apb_write(12'h004, 32'hFFFF_FFFF, '0);
        apb_read(12'h004, 32'hA5A5_1234, 1'b0, "R9 status write ignored");
        status_in = 32'h0F0F_00FF;
        apb_read(12'h004, 32'h0F0F_00FF, 1'b0, "R9 status is live");

        // R10 flags
        irq_pulse(32'h0000_0011);
        apb_read(12'h008, 32'h0000_0011, 1'b0, "R10 flags set by irq");
        apb_write(12'h008, 32'h0000_0001, '0);
        apb_read(12'h008, 32'h0000_0010, 1'b0, "R10 write-1 clears");
        apb_write(12'h008, 32'h0000_0010, 32'h0000_0010);
        apb_read(12'h008, 32'h0000_0010, 1'b0, "R10 set wins over clear");
        apb_write(12'h008, 32'h0000_0010, '0);
        apb_read(12'h008, 32'h0, 1'b0, "R10 cleared");

        // R7 FIFO reads and pop
        apb_read(12'h00C, 32'hDEAD_BEEF, 1'b1, "R3 fifo head read");
        fifo_head = 32'h0BAD_CAFE;
        apb_read(12'h00C, 32'h0BAD_CAFE, 1'b1, "R7 second fifo read");
        apb_write(12'h00C, 32'h1234_5678, '0);
        apb_read(12'h000, 32'h1357_9BDF, 1'b0, "R7 no pop on other read");

        // R4 unmapped offsets
        apb_read(12'h014, 32'h0, 1'b0, "R4 unmapped 0x014");
        apb_read(12'h002, 32'h0, 1'b0, "R4 unaligned 0x002");
        apb_read(12'h00E, 32'h0, 1'b0, "R4 unaligned 0x00E");
        apb_read(12'h800, 32'h0, 1'b0, "R4 unmapped 0x800");
        apb_read(12'hFFC, 32'h0, 1'b0, "R4 unmapped 0xFFC");

        // R5 command location
        apb_write(12'h010, 32'hCAFE_F00D, '0);
        @(negedge pclk);
        chk(cmd_pulse == 1'b1, "R5 cmd pulse high", 32'(cmd_pulse), 1);
        chk(cmd_word == 32'hCAFE_F00D, "R5 cmd word", cmd_word, 32'hCAFE_F00D);
        @(negedge pclk);
        chk(cmd_pulse == 1'b0, "R5 cmd pulse one cycle", 32'(cmd_pulse), 0);
        apb_read(12'h010, 32'h0, 1'b0, "R5 cmd reads zero");

        repeat (3) @(negedge pclk);
        chk(pops_seen == pops_exp, "R7 pop count", 32'(pops_seen), 32'(pops_exp));
        chk(sbq.size() == 0, "R2 all reads completed", 32'(sbq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule